// File: doc/BRIEF.md
# Two-Bank Edge/Level Interrupt Merger

The block collects 64 interrupt request lines and drives a single interrupt output to a CPU. Internally the lines are split into two banks of 32 bits. Every bank keeps a set of sticky event flags, an enable mask and a copy of the current line levels. A per-bit selector, fixed at build time, marks some bits as level-type. A level-type bit asks for service only while its line is high. Every other bit latches an event on a rising edge, and that event stays set until software clears it.

Software reaches the block through a 32-bit register port with a single-cycle request. It can read the events, the mask and the levels of each bank, write the mask, and clear events by writing ones to a clear register. Writes to the clear register never affect level-type bits. The upper half of the line numbers (32..63) feeds bank 0 and the lower half (0..31) feeds bank 1. Register data is presented with little-endian byte order, so data bit k is line bit k of the bank.

Top module: `irq_merge2`

## Requirements
- R1: After reset, the events, mask and levels of both banks read 0 and `cpu_irq` is low.
- R2: Line n belongs to bank 1 − (n div 32), at bit n mod 32. The levels register of a bank (offset 0xC) shows the line values sampled on the previous clock edge.
- R3: A bit that is not level-type sets its event flag when its sampled line goes from 0 to 1. The flag stays set after the line falls. No flag is set without such a rise.
- R4: Bank 1 bits 20 to 28 (lines 20..28) are level-type and bank 0 has none. A level-type bit never sets an event flag, and it is pending for as long as its line is high.
- R5: A write to offset 0x8 clears every event flag whose data bit is 1, with level-type bits removed from the data first. When a rise and a clear hit the same bit in the same cycle, the flag ends up set.
- R6: The mask is written and read at offset 0x4. A bank's pending bits are (events OR (levels AND level-type)) AND mask. `cpu_irq` is high one cycle after any bank has a pending bit, and low one cycle after none has.
- R7: Address bits [11:4] select the bank: the value 1 selects bank 0 (0x10..0x1F) and the value 2 selects bank 1 (0x20..0x2F). Any other value reads 0 and ignores writes. Within a bank, offsets other than 0x0, 0x4, 0x8 and 0xC read 0 and ignore writes, and offset 0x8 reads 0.
- R8: Read data appears on `rsp_rdata` in the cycle after a read request. It is 0 in the cycle after any cycle with no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 64 | Interrupt request lines, line n at bit n |
| req_valid | input | 1 | Register request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Register byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| cpu_irq | output | 1 | Registered interrupt output to the CPU |

## Verification
The assertions assume that reset is held low from time zero and that each line's sampled value reflects the line at the previous edge. They also assume that a clear can only occur in a cycle whose request has write set and offset 0x8. The stimulus drives every input half a period away from the sampling edge. It flips each line with a probability of about one in eight per cycle, so rises, falls and held levels all occur on edge-type and level-type bits. Requests are drawn mostly from the valid register offsets, with a share of unmapped slots and odd offsets mixed in.

// File: rtl/irq_merge2.sv
module irq_merge2 #(
  parameter int          BANK_W = 32,
  parameter int          ADDR_W = 12,
  parameter logic [31:0] LT_BANK0 = 32'h0000_0000,
  parameter logic [31:0] LT_BANK1 = 32'h1FF0_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*BANK_W-1:0] irq_lines,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [BANK_W-1:0]   req_wdata,
  output logic [BANK_W-1:0]   rsp_rdata,
  output logic                cpu_irq
);
  localparam int NBANK  = 2;
  localparam int LINES  = NBANK * BANK_W;
  localparam int SLOT_W = ADDR_W - 4;
  localparam logic [3:0] OFF_EVT = 4'h0;
  localparam logic [3:0] OFF_MSK = 4'h4;
  localparam logic [3:0] OFF_CLR = 4'h8;
  localparam logic [3:0] OFF_LVL = 4'hC;
  localparam logic [LINES-1:0] LT_ALL = {LT_BANK1[BANK_W-1:0], LT_BANK0[BANK_W-1:0]};

  logic [LINES-1:0] in_q, evt_q, msk_q;
  logic [NBANK-1:0] pend;
  logic [BANK_W-1:0] rd_val;

  wire [LINES-1:0] bk_in = {irq_lines[BANK_W-1:0], irq_lines[LINES-1:BANK_W]};
  wire [LINES-1:0] rise  = bk_in & ~in_q;
  wire [SLOT_W-1:0] slot = req_addr[ADDR_W-1:4];
  wire [3:0] off = req_addr[3:0];
  wire wr = req_valid && req_write;
  wire rd = req_valid && !req_write;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) in_q <= '0;
    else        in_q <= bk_in;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    wire [BANK_W-1:0] lt  = LT_ALL[b*BANK_W +: BANK_W];
    wire              hit = (slot == SLOT_W'(b + 1));
    wire [BANK_W-1:0] clr = (wr && hit && off == OFF_CLR) ? (req_wdata & ~lt) : '0;
    wire [BANK_W-1:0] evt = evt_q[b*BANK_W +: BANK_W];
    wire [BANK_W-1:0] lvl = in_q[b*BANK_W +: BANK_W];
    wire [BANK_W-1:0] msk = msk_q[b*BANK_W +: BANK_W];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        evt_q[b*BANK_W +: BANK_W] <= '0;
        msk_q[b*BANK_W +: BANK_W] <= '0;
      end else begin
        evt_q[b*BANK_W +: BANK_W] <= (evt & ~clr) | (rise[b*BANK_W +: BANK_W] & ~lt);
        if (wr && hit && off == OFF_MSK) msk_q[b*BANK_W +: BANK_W] <= req_wdata;
      end

    assign pend[b] = |((evt | (lvl & lt)) & msk);
  end

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < NBANK; b++)
      if (slot == SLOT_W'(b + 1))
        case (off)
          OFF_EVT: rd_val = evt_q[b*BANK_W +: BANK_W];
          OFF_MSK: rd_val = msk_q[b*BANK_W +: BANK_W];
          OFF_LVL: rd_val = in_q[b*BANK_W +: BANK_W];
          default: rd_val = '0;
        endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsp_rdata <= '0;
      cpu_irq   <= 1'b0;
    end else begin
      rsp_rdata <= rd ? rd_val : '0;
      cpu_irq   <= |pend;
    end
endmodule

module irq_merge2_chk #(
  parameter int          BANK_W = 32,
  parameter int          ADDR_W = 12,
  parameter logic [31:0] LT_BANK0 = 32'h0000_0000,
  parameter logic [31:0] LT_BANK1 = 32'h1FF0_0000
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2*BANK_W-1:0] irq_lines,
  input logic                req_valid,
  input logic                req_write,
  input logic [ADDR_W-1:0]   req_addr,
  input logic [BANK_W-1:0]   rsp_rdata,
  input logic                cpu_irq,
  input logic [2*BANK_W-1:0] in_q,
  input logic [2*BANK_W-1:0] evt_q,
  input logic [2*BANK_W-1:0] msk_q
);
  localparam int LINES = 2 * BANK_W;
  localparam logic [LINES-1:0] LT_ALL = {LT_BANK1[BANK_W-1:0], LT_BANK0[BANK_W-1:0]};
  wire [LINES-1:0] mapped = {irq_lines[BANK_W-1:0], irq_lines[LINES-1:BANK_W]};
  wire clr_req = req_valid && req_write && req_addr[3:0] == 4'h8;

  AST_LEVELS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> in_q == $past(mapped)); // R2
  AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_req |=> (($past(evt_q) & ~evt_q) == '0)); // R3
  AST_EVENT_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(evt_q) & ~($past(mapped) & ~$past(in_q))) == '0)); // R3
  AST_LEVEL_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (evt_q & LT_ALL) == '0); // R4
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    msk_q == '0 |=> !cpu_irq); // R6
  AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> rsp_rdata == '0); // R8
endmodule

bind irq_merge2 irq_merge2_chk #(
  .BANK_W(BANK_W), .ADDR_W(ADDR_W), .LT_BANK0(LT_BANK0), .LT_BANK1(LT_BANK1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .req_valid(req_valid),
  .req_write(req_write), .req_addr(req_addr), .rsp_rdata(rsp_rdata),
  .cpu_irq(cpu_irq), .in_q(in_q), .evt_q(evt_q), .msk_q(msk_q)
);

// File: tb/test_irq_merge2.sv
module test_irq_merge2;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_lines = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        cpu_irq;

  always #2.5 clk = ~clk;

  irq_merge2 i_irq_merge2 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .cpu_irq(cpu_irq)
  );

  int vectors = 0, errors = 0;
  logic [31:0] m_ev [2], m_mk [2], m_lv [2], m_lt [2];
  logic [63:0] m_prev;

  function automatic logic [31:0] m_read(logic [11:0] a);
    int b;
    if (a[11:4] == 8'd1) b = 0;
    else if (a[11:4] == 8'd2) b = 1;
    else return '0;
    case (a[3:0])
      4'h0: return m_ev[b];
      4'h4: return m_mk[b];
      4'hC: return m_lv[b];
      default: return '0;
    endcase
  endfunction

  function automatic logic m_irq();
    logic any = 1'b0;
    for (int b = 0; b < 2; b++)
      if (((m_ev[b] | (m_lv[b] & m_lt[b])) & m_mk[b]) != '0) any = 1'b1;
    return any;
  endfunction

  task automatic m_reset();
    m_lt[0] = 32'h0; m_lt[1] = 32'h1FF0_0000;
    for (int b = 0; b < 2; b++) begin m_ev[b] = '0; m_mk[b] = '0; m_lv[b] = '0; end
    m_prev = '0;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic [63:0] l, bit v, bit w, logic [11:0] a, logic [31:0] d, string tag);
    logic [31:0] exp_rd, ev_n [2], mk_n [2];
    logic exp_irq;
    @(negedge clk);
    irq_lines = l; req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    exp_rd  = (v && !w) ? m_read(a) : '0;
    exp_irq = m_irq();
    for (int b = 0; b < 2; b++) begin
      logic [31:0] clr = '0;
      if (v && w && a[11:4] == 8'(b + 1) && a[3:0] == 4'h8) clr = d & ~m_lt[b];
      ev_n[b] = m_ev[b] & ~clr;
      mk_n[b] = (v && w && a[11:4] == 8'(b + 1) && a[3:0] == 4'h4) ? d : m_mk[b];
    end
    for (int n = 0; n < 64; n++) begin
      int b = 1 - (n >> 5);
      int i = n & 31;
      if (l[n] && !m_prev[n] && !m_lt[b][i]) ev_n[b][i] = 1'b1;
      m_lv[b][i] = l[n];
    end
    m_prev = l;
    for (int b = 0; b < 2; b++) begin m_ev[b] = ev_n[b]; m_mk[b] = mk_n[b]; end
    #1;
    check({tag, " rdata"}, rsp_rdata, exp_rd);
    check({tag, " irq(R6)"}, {31'b0, cpu_irq}, {31'b0, exp_irq});
  endtask

  logic finished = 1'b0;
  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] l;
    logic [11:0] picks [12];
    void'($urandom(32'd1234));
    picks = '{12'h010, 12'h014, 12'h018, 12'h01C, 12'h020, 12'h024,
              12'h028, 12'h02C, 12'h000, 12'h034, 12'h011, 12'h026};
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    foreach (picks[k]) step('0, 1, 0, picks[k], '0, "R1");
    // R2: lower lines land in bank 1, upper lines in bank 0
    l = 64'h1;
    step(l, 0, 0, '0, '0, "R2");
    step(l, 1, 0, 12'h02C, '0, "R2");
    step(l, 1, 0, 12'h01C, '0, "R2");
    l[32] = 1'b1;
    step(l, 1, 0, 12'h01C, '0, "R2");
    // R3: sticky capture on line 40
    l[40] = 1'b1; step(l, 0, 0, '0, '0, "R3");
    l[40] = 1'b0; step(l, 0, 0, '0, '0, "R3");
    step(l, 1, 0, 12'h010, '0, "R3");
    // R4: level-type line 22
    l[22] = 1'b1; step(l, 0, 0, '0, '0, "R4");
    step(l, 1, 0, 12'h020, '0, "R4");
    step(l, 1, 1, 12'h024, 32'h0040_0000, "R4");
    step(l, 0, 0, '0, '0, "R4");
    l[22] = 1'b0; step(l, 0, 0, '0, '0, "R4");
    step(l, 0, 0, '0, '0, "R4");
    // R6: mask an event, see irq, unmask
    step(l, 1, 1, 12'h014, 32'h0000_0100, "R6");
    step(l, 1, 0, 12'h014, '0, "R6");
    step(l, 1, 1, 12'h014, 32'h0, "R6");
    step(l, 0, 0, '0, '0, "R6");
    // R5: clear everything, then capture against clear
    step(l, 1, 1, 12'h018, 32'hFFFF_FFFF, "R5");
    l[1] = 1'b1;
    step(l, 1, 1, 12'h028, 32'hFFFF_FFFF, "R5");
    step(l, 1, 0, 12'h020, '0, "R5");
    step(l, 1, 0, 12'h010, '0, "R5");
    // R7: unmapped slots and offsets
    step(l, 1, 1, 12'h034, 32'hFFFF_FFFF, "R7");
    step(l, 1, 1, 12'h004, 32'hFFFF_FFFF, "R7");
    step(l, 1, 1, 12'h015, 32'hFFFF_FFFF, "R7");
    step(l, 1, 0, 12'h034, '0, "R7");
    step(l, 1, 0, 12'h014, '0, "R7");
    step(l, 1, 0, 12'h028, '0, "R7");
    // R8 and mixed random traffic
    for (int c = 0; c < 4000; c++) begin
      logic [63:0] flip = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      logic [11:0] a = ($urandom % 8 == 0) ? 12'($urandom) : picks[$urandom % 12];
      l = l ^ flip;
      step(l, ($urandom % 2) == 1, ($urandom % 3) == 0, a, $urandom, "R8");
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule